// File: doc/BRIEF.md
# Thread-Aware Branch Predictor

This block holds the branch-prediction state of a core that runs several hardware threads at once. Each structure is kept according to how it behaves when threads share it. The target buffer is one shared array, and every entry records which thread wrote it. The direction counters are one shared array that holds no thread information. Each thread has its own global history register and its own return stack, because that state only means something in its own thread's order.

Each cycle, fetch presents a PC and a thread number. The block answers in the same cycle, using only combinational logic: a target hit flag, a target, and a taken/not-taken guess. The back end reports resolved branches on a separate update port, and these reports train the tables. A per-thread flush resets that thread's private speculative state and nothing else.

Top module: `tbp_front`

## Requirements
- R1: After reset no fetch hits the target buffer, and every direction counter starts at 1 (weakly not taken), so `pred_taken` is 0. With `fetch_valid` low, all three outputs are 0.
- R2: A fetch hits only when three conditions hold at index `pc[7:2]`: the entry is valid, the stored tag `pc[31:8]` matches, and the stored thread number equals `fetch_tid`. An entry written by another thread gives a miss.
- R3: An update with `upd_taken`=1 overwrites the target entry at its index, including the thread number. A hit on that PC and thread is seen in the cycle after the update.
- R4: The direction counters are shared with no thread tag. Training by one thread changes the prediction another thread sees at the same index.
- R5: The counter index is `pc[9:2]` XOR the requesting thread's 8-bit history. A conditional update (`upd_cond`=1) shifts its thread's history left and inserts `upd_taken` at bit 0. The histories of other threads do not change.
- R6: Counters are 2-bit saturating: taken adds 1 up to 3, not taken subtracts 1 down to 0. The index uses the thread's history before that update's shift. `pred_taken` is counter bit 1.
- R7: An update with `upd_is_call` pushes `upd_pc`+4 on that thread's return stack. An update with `upd_is_ret` pops it. When both flags are set, only the push happens. A hit on an entry written by a return update supplies the thread's stack top as the target, ahead of the stored target.
- R8: Each thread's stack holds 8 entries. A push onto a full stack overwrites the oldest entry. A pop from an empty stack does nothing. A return entry with an empty stack falls back to the stored target.
- R9: A flush clears only that thread's history and return stack, and it overrides a same-cycle update to them. The shared arrays keep their contents and still take that cycle's update.
- R10: An update with `upd_taken`=0 leaves the target buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_pc | input | 32 | Fetch address |
| fetch_tid | input | 2 | Fetching thread |
| upd_valid | input | 1 | Resolution update present |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_tid | input | 2 | Thread of the resolved branch |
| upd_cond | input | 1 | Branch is conditional (trains counters and history) |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target |
| upd_is_call | input | 1 | Branch is a call |
| upd_is_ret | input | 1 | Branch is a return |
| flush_valid | input | 1 | Flush request |
| flush_tid | input | 2 | Thread to flush |
| pred_hit | output | 1 | Target buffer hit |
| pred_target | output | 32 | Predicted target (0 on miss) |
| pred_taken | output | 1 | Predicted direction |

## Verification
Directed sequences separate the cases that shared and private state could confuse:
- The same PC is fetched by two threads around an eviction, which tells tag matching apart from thread matching.
- Counters are trained by one thread and read by another, with flushes holding history at zero, which shows the counters are shared and saturate at both ends.
- Calls and returns are pushed past the stack depth and popped past empty. This tells stack-supplied targets apart from stored targets.

A long mixed run follows. It uses a small PC set with aliasing tags, random threads, and flushes that collide with updates. It is checked every cycle against a queue-based model.

// File: rtl/tbp_front.sv
module tbp_front #(
  parameter int NT    = 4,
  parameter int PCW   = 32,
  parameter int BTB_N = 64,
  parameter int BHT_N = 256,
  parameter int RAS_N = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                fetch_valid,
  input  logic [PCW-1:0]                      fetch_pc,
  input  logic [(NT>1?$clog2(NT):1)-1:0]      fetch_tid,
  input  logic                                upd_valid,
  input  logic [PCW-1:0]                      upd_pc,
  input  logic [(NT>1?$clog2(NT):1)-1:0]      upd_tid,
  input  logic                                upd_cond,
  input  logic                                upd_taken,
  input  logic [PCW-1:0]                      upd_target,
  input  logic                                upd_is_call,
  input  logic                                upd_is_ret,
  input  logic                                flush_valid,
  input  logic [(NT>1?$clog2(NT):1)-1:0]      flush_tid,
  output logic                                pred_hit,
  output logic [PCW-1:0]                      pred_target,
  output logic                                pred_taken
);
  localparam int TIDW = NT > 1 ? $clog2(NT) : 1;
  localparam int BIW  = $clog2(BTB_N);
  localparam int HW   = $clog2(BHT_N);
  localparam int TAGW = PCW - 2 - BIW;
  localparam int RPW  = RAS_N > 1 ? $clog2(RAS_N) : 1;
  localparam int RCW  = $clog2(RAS_N + 1);

  logic [BTB_N-1:0]          btb_v, btb_r;
  logic [TAGW-1:0]           btb_tag [BTB_N];
  logic [TIDW-1:0]           btb_tid [BTB_N];
  logic [PCW-1:0]            btb_tgt [BTB_N];
  logic [1:0]                bht     [BHT_N];
  logic [NT-1:0][HW-1:0]     ghr;
  logic [PCW-1:0]            ras     [NT][RAS_N];
  logic [NT-1:0][RPW-1:0]    ras_ptr;
  logic [NT-1:0][RCW-1:0]    ras_cnt;

  wire unused_pc_lsb = &{1'b0, fetch_pc[1:0]};

  // lookup
  wire [BIW-1:0] f_bi  = fetch_pc[2 +: BIW];
  wire [HW-1:0]  f_hi  = fetch_pc[2 +: HW] ^ ghr[fetch_tid];
  wire [RPW-1:0] f_top = ras_ptr[fetch_tid] - 1'b1;
  wire f_hit = fetch_valid && btb_v[f_bi] &&
               btb_tag[f_bi] == fetch_pc[PCW-1 -: TAGW] &&
               btb_tid[f_bi] == fetch_tid;
  wire f_use_ras = btb_r[f_bi] && ras_cnt[fetch_tid] != '0;

  assign pred_hit    = f_hit;
  assign pred_target = !f_hit ? '0 : f_use_ras ? ras[fetch_tid][f_top] : btb_tgt[f_bi];
  assign pred_taken  = fetch_valid && bht[f_hi][1];

  // update
  wire [BIW-1:0] u_bi  = upd_pc[2 +: BIW];
  wire [HW-1:0]  u_hi  = upd_pc[2 +: HW] ^ ghr[upd_tid];
  wire           wr_btb = upd_valid && upd_taken;
  wire           push   = upd_valid && upd_is_call;
  wire           pop    = upd_valid && upd_is_ret && !upd_is_call;
  wire [1:0]     ctr    = bht[u_hi];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btb_v   <= '0;
      btb_r   <= '0;
      ghr     <= '0;
      ras_ptr <= '0;
      ras_cnt <= '0;
      for (int i = 0; i < BHT_N; i++) bht[i] <= 2'b01;
    end else begin
      if (wr_btb) begin
        btb_v[u_bi] <= 1'b1;
        btb_r[u_bi] <= upd_is_ret;
      end
      if (upd_valid && upd_cond)
        bht[u_hi] <= upd_taken ? (ctr == 2'b11 ? ctr : ctr + 2'b01)
                               : (ctr == 2'b00 ? ctr : ctr - 2'b01);
      for (int t = 0; t < NT; t++) begin
        if (flush_valid && flush_tid == TIDW'(t)) begin
          ghr[t]     <= '0;
          ras_ptr[t] <= '0;
          ras_cnt[t] <= '0;
        end else if (upd_valid && upd_tid == TIDW'(t)) begin
          if (upd_cond) ghr[t] <= {ghr[t][HW-2:0], upd_taken};
          if (push) begin
            ras_ptr[t] <= ras_ptr[t] + 1'b1;
            if (ras_cnt[t] != RCW'(RAS_N)) ras_cnt[t] <= ras_cnt[t] + 1'b1;
          end else if (pop && ras_cnt[t] != '0) begin
            ras_ptr[t] <= ras_ptr[t] - 1'b1;
            ras_cnt[t] <= ras_cnt[t] - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_btb) begin
      btb_tag[u_bi] <= upd_pc[PCW-1 -: TAGW];
      btb_tid[u_bi] <= upd_tid;
      btb_tgt[u_bi] <= upd_target;
    end
    if (push) ras[upd_tid][ras_ptr[upd_tid]] <= upd_pc + PCW'(4);
  end
endmodule

// File: rtl/tbp_front_chk.sv
module tbp_front_chk #(
  parameter int NT    = 4,
  parameter int PCW   = 32,
  parameter int BHT_N = 256,
  parameter int RAS_N = 8
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                fetch_valid,
  input logic [PCW-1:0]                      fetch_pc,
  input logic [(NT>1?$clog2(NT):1)-1:0]      fetch_tid,
  input logic                                upd_valid,
  input logic [PCW-1:0]                      upd_pc,
  input logic [(NT>1?$clog2(NT):1)-1:0]      upd_tid,
  input logic                                upd_cond,
  input logic                                upd_taken,
  input logic                                upd_is_call,
  input logic                                flush_valid,
  input logic [(NT>1?$clog2(NT):1)-1:0]      flush_tid,
  input logic                                pred_hit,
  input logic [NT-1:0][$clog2(BHT_N)-1:0]    ghr,
  input logic [NT-1:0][$clog2(RAS_N+1)-1:0]  ras_cnt
);
  localparam int HW  = $clog2(BHT_N);
  localparam int RCW = $clog2(RAS_N + 1);

  wire own_flush = flush_valid && flush_tid == upd_tid;

  p_clean_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pred_hit);

  p_refill_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=>
      (!(fetch_valid && fetch_pc == $past(upd_pc) && fetch_tid == $past(upd_tid)) || pred_hit));

  p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_cond && !own_flush) |=>
      ghr[$past(upd_tid)] == {$past(ghr[upd_tid][HW-2:0]), $past(upd_taken)});

  p_ras_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_is_call && !own_flush) |=>
      ras_cnt[$past(upd_tid)] == ($past(ras_cnt[upd_tid]) == RCW'(RAS_N) ? RCW'(RAS_N)
                                                                         : $past(ras_cnt[upd_tid]) + RCW'(1)));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (ghr[$past(flush_tid)] == '0 && ras_cnt[$past(flush_tid)] == '0));

  for (genvar t = 0; t < NT; t++) begin : g_thr
    p_ras_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ras_cnt[t] <= RCW'(RAS_N));
  end
endmodule

bind tbp_front tbp_front_chk #(.NT(NT), .PCW(PCW), .BHT_N(BHT_N), .RAS_N(RAS_N)) u_chk (.*);

// File: tb/tbp_front_bench.sv
module tbp_front_bench;
  logic clk = 0, rst_n = 0;
  logic fetch_valid = 0; logic [31:0] fetch_pc = 0; logic [1:0] fetch_tid = 0;
  logic upd_valid = 0; logic [31:0] upd_pc = 0; logic [1:0] upd_tid = 0;
  logic upd_cond = 0, upd_taken = 0; logic [31:0] upd_target = 0;
  logic upd_is_call = 0, upd_is_ret = 0;
  logic flush_valid = 0; logic [1:0] flush_tid = 0;
  logic pred_hit, pred_taken; logic [31:0] pred_target;

  tbp_front u_tbp_front (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  bit          m_v [64];
  bit          m_r [64];
  int unsigned m_tag [64];
  int          m_tid [64];
  logic [31:0] m_tgt [64];
  int          m_bht [256];
  int          m_ghr [4];
  logic [31:0] m_ras [4][$];

  task automatic m_reset();
    for (int i = 0; i < 64; i++) m_v[i] = 0;
    for (int i = 0; i < 256; i++) m_bht[i] = 1;
    for (int t = 0; t < 4; t++) begin m_ghr[t] = 0; m_ras[t].delete(); end
  endtask

  task automatic m_update();
    int bi, hi, t;
    bit fl;
    if (upd_valid) begin
      t  = int'(upd_tid);
      bi = int'(upd_pc[7:2]);
      hi = int'(upd_pc[9:2]) ^ m_ghr[t];
      fl = flush_valid && flush_tid == upd_tid;
      if (upd_taken) begin
        m_v[bi] = 1; m_r[bi] = upd_is_ret; m_tag[bi] = upd_pc[31:8];
        m_tid[bi] = t; m_tgt[bi] = upd_target;
      end
      if (upd_cond) begin
        if (upd_taken && m_bht[hi] < 3) m_bht[hi]++;
        if (!upd_taken && m_bht[hi] > 0) m_bht[hi]--;
        if (!fl) m_ghr[t] = ((m_ghr[t] << 1) | int'(upd_taken)) & 255;
      end
      if (!fl) begin
        if (upd_is_call) begin
          m_ras[t].push_back(upd_pc + 32'd4);
          if (m_ras[t].size() > 8) void'(m_ras[t].pop_front());
        end else if (upd_is_ret && m_ras[t].size() > 0) void'(m_ras[t].pop_back());
      end
    end
    if (flush_valid) begin
      m_ghr[flush_tid] = 0;
      m_ras[flush_tid].delete();
    end
  endtask

  task automatic check(string req);
    bit eh, et; logic [31:0] eg; int bi, hi, t;
    t  = int'(fetch_tid);
    bi = int'(fetch_pc[7:2]);
    hi = int'(fetch_pc[9:2]) ^ m_ghr[t];
    eh = fetch_valid && m_v[bi] && m_tag[bi] == fetch_pc[31:8] && m_tid[bi] == t;
    eg = !eh ? 32'd0 : (m_r[bi] && m_ras[t].size() > 0) ? m_ras[t][$] : m_tgt[bi];
    et = fetch_valid && m_bht[hi] >= 2;
    checks += 3;
    if (pred_hit !== eh) begin fails++; $display("FAIL %s pred_hit act=%0b exp=%0b pc=%h tid=%0d", req, pred_hit, eh, fetch_pc, t); end
    if (pred_target !== eg) begin fails++; $display("FAIL %s pred_target act=%h exp=%h pc=%h tid=%0d", req, pred_target, eg, fetch_pc, t); end
    if (pred_taken !== et) begin fails++; $display("FAIL %s pred_taken act=%0b exp=%0b pc=%h tid=%0d", req, pred_taken, et, fetch_pc, t); end
  endtask

  task automatic clr();
    fetch_valid = 0; upd_valid = 0; flush_valid = 0;
    upd_cond = 0; upd_taken = 0; upd_is_call = 0; upd_is_ret = 0;
  endtask

  task automatic fetch(logic [31:0] pc, int tid);
    fetch_valid = 1; fetch_pc = pc; fetch_tid = 2'(tid);
  endtask

  task automatic upd(logic [31:0] pc, int tid, bit cond, bit tk, logic [31:0] tgt, bit call, bit ret);
    upd_valid = 1; upd_pc = pc; upd_tid = 2'(tid); upd_cond = cond; upd_taken = tk;
    upd_target = tgt; upd_is_call = call; upd_is_ret = ret;
  endtask

  task automatic flush(int tid);
    flush_valid = 1; flush_tid = 2'(tid);
  endtask

  task automatic tick(string req);
    #2 check(req);
    @(posedge clk); #1 m_update();
    @(negedge clk); clr();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty after reset, and quiet without fetch
    fetch(32'h100, 0); tick("R1");
    tick("R1");
    // R2/R3: thread-tagged hits and overwrite
    upd(32'h2040, 0, 0, 1, 32'h9000, 0, 0); tick("R3");
    fetch(32'h2040, 0); tick("R2");
    fetch(32'h2040, 1); tick("R2");
    fetch(32'h3040, 0); tick("R2");
    upd(32'h2040, 1, 0, 1, 32'hA000, 0, 0); tick("R3");
    fetch(32'h2040, 0); tick("R3");
    fetch(32'h2040, 1); tick("R3");
    // R10: not-taken leaves BTB alone
    upd(32'h2040, 1, 1, 0, 32'hBBBB, 0, 0); tick("R10");
    fetch(32'h2040, 1); tick("R10");
    upd(32'h5010, 2, 1, 0, 32'h1234, 0, 0); tick("R10");
    fetch(32'h5010, 2); tick("R10");
    // R4/R6: train shared counter from thread 0 with history held at zero
    flush(0); flush_tid = 0; tick("R9");
    for (int i = 0; i < 3; i++) begin
      upd(32'h400, 0, 1, 1, 32'h800, 0, 0); flush(0); tick("R6");
    end
    fetch(32'h400, 3); tick("R4");
    fetch(32'h400, 0); tick("R4");
    for (int i = 0; i < 5; i++) begin
      upd(32'h400, 3, 1, 0, 32'h800, 0, 0); flush(3); tick("R6");
    end
    fetch(32'h400, 0); tick("R6");
    upd(32'h400, 3, 1, 1, 32'h800, 0, 0); flush(3); tick("R6");
    fetch(32'h400, 0); tick("R6");
    // R5: per-thread history alters the index
    upd(32'h400, 1, 1, 1, 32'h800, 0, 0); tick("R5");
    fetch(32'h400, 1); tick("R5");
    fetch(32'h400, 2); tick("R5");
    // R7: call pushes, return entry uses stack top
    upd(32'h6000, 0, 0, 1, 32'h7000, 1, 0); tick("R7");
    upd(32'h7080, 0, 0, 1, 32'h6004, 0, 1); tick("R7");
    fetch(32'h7080, 0); tick("R8");
    upd(32'h6100, 0, 0, 1, 32'h7000, 1, 0); tick("R7");
    fetch(32'h7080, 0); tick("R7");
    fetch(32'h7080, 2); tick("R7");
    upd(32'h6200, 0, 0, 1, 32'h7000, 1, 1); tick("R7");
    fetch(32'h7080, 0); tick("R7");
    // R8: overflow and pop past empty
    for (int i = 0; i < 11; i++) begin
      upd(32'h6000 + 32'(i * 16), 0, 0, 1, 32'h7000, 1, 0); tick("R8");
    end
    for (int i = 0; i < 10; i++) begin
      upd(32'h7080, 0, 0, 1, 32'h6004, 0, 1); fetch(32'h7080, 0); tick("R8");
    end
    // R9: flush of one thread, same-cycle update from it and another
    upd(32'h6300, 1, 0, 1, 32'h7000, 1, 0); tick("R9");
    upd(32'h7080, 1, 0, 1, 32'h6004, 0, 1); tick("R9");
    upd(32'h6400, 1, 0, 1, 32'h7000, 1, 0); tick("R9");
    upd(32'h6500, 2, 0, 1, 32'h7000, 1, 0); flush(2); tick("R9");
    fetch(32'h7080, 1); tick("R9");
    upd(32'h6600, 1, 1, 1, 32'h7000, 1, 0); flush(1); tick("R9");
    fetch(32'h7080, 1); tick("R9");
    fetch(32'h2040, 1); tick("R9");
    // mixed traffic
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(0, 3) != 0)
        fetch(32'h1000 + 32'($urandom_range(0, 31) << 2) + 32'($urandom_range(0, 1) << 8), $urandom_range(0, 3));
      if ($urandom_range(0, 1) != 0) begin
        int k;
        k = $urandom_range(0, 7);
        upd(32'h1000 + 32'($urandom_range(0, 31) << 2) + 32'($urandom_range(0, 1) << 8),
            $urandom_range(0, 3), k < 5, $urandom_range(0, 2) != 0,
            32'($urandom()) & 32'hFFFF_FFFC, k == 5, k >= 6);
      end
      if ($urandom_range(0, 15) == 0) flush($urandom_range(0, 3));
      tick("R5");
    end
    done = 1;
    finish_run();
  end
endmodule